// File: doc/BRIEF.md
# Static Memory Timing Sequencer

This block runs single accesses to one bank of asynchronous static memory (SRAM, NOR flash or a memory-mapped peripheral). A core-side request port hands it one read or write at a time; the block then drives chip select, output enable, write enable, per-byte lane strobes, the address and the write data. It returns read data together with a completion pulse. Every phase length is set in core clock cycles by configuration inputs. Each timing field has its own offset rule.

The same configuration inputs also set the bus width, the chip-select and lane-strobe polarities, and an asynchronous four-beat page-read mode. A page read has its own wait for the later beats. An optional wait input lets a slow device stretch the last cycle of a beat. The stretch is bounded by a timeout counted in units of sixteen cycles. A write to a protected bank, a request under the reserved width code, and a timed-out access all finish with an error flag.

Top module: `static_mem_sequencer`

## Requirements
- R1: A request is taken only in a cycle where `req_ready` is 1. Chip select becomes active in the cycle after the request is taken. For a non-page read it stays active for `cfg_rd_wait`+1 cycles, provided the wait input does not hold the access.
- R2: On a read, `mem_oe_n` is 0 in every chip-select cycle whose index, counted from 0 at the first chip-select cycle, is at least `cfg_oe_lead`. With a lead of 0 it is low from the first cycle. `mem_oe_n` and `mem_we_n` are never 0 together.
- R3: A write holds chip select for `cfg_wr_wait`+2 cycles. `mem_we_n` is 0 from index `cfg_we_lead`+1 to the end of chip select. `mem_dout` carries the request data with `mem_dout_en`=1 from the first chip-select cycle.
- R4: With `cfg_page_en`=1, a read makes four beats under one unbroken chip select and output enable. The first beat lasts `cfg_rd_wait`+1 cycles and each later beat lasts `cfg_pg_wait`+1 cycles. Beat i uses address base + i·(bytes per width). `rsp_valid` pulses once per beat, in the cycle after that beat ends.
- R5: `done` pulses in the cycle after the last chip-select cycle. `req_ready` is then 0 for `cfg_turn`+1 cycles, starting with the `done` cycle, and chip select stays inactive during that time.
- R6: Width code 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits. The active lanes are `req_be` masked to the lower 1, 2 or 4 lanes. Read-data bytes above the width return 0.
- R7: `cfg_cs_high`=0 makes `mem_cs` active low. `cfg_cs_high`=1 makes it active high.
- R8: `mem_lane` bit i is active on lane i during output enable or write enable. With `cfg_lane_low`=0, the active level is 1 on reads and 0 on writes. With `cfg_lane_low`=1, the active level is 0 on both.
- R9: With `cfg_ext_en`=1, `mem_wait`=1 in the last cycle of a beat holds that cycle. With `cfg_ext_en`=0, `mem_wait` has no effect.
- R10: When the hold lasts 16·(`cfg_ext_tmo`+1) consecutive cycles, the access ends at once with `done` and `err`, and no response is given for the held beat.
- R11: With `cfg_wprot`=1, a write finishes with `done`=`err`=1 in the cycle after it is taken, and no chip select or write enable is driven. Reads are unaffected.
- R12: With width code 3, any request finishes with `done`=`err`=1 in the cycle after it is taken, and no strobes are driven.
- R13: After reset, `req_ready`=1, chip select is inactive, `mem_oe_n`=`mem_we_n`=1, and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_we_lead | input | 4 | write-enable lead after chip select (n+1 cycles) |
| cfg_oe_lead | input | 4 | output-enable lead after chip select (n cycles) |
| cfg_rd_wait | input | 5 | read or first page beat length (n+1) |
| cfg_pg_wait | input | 5 | later page beat length (n+1) |
| cfg_wr_wait | input | 5 | write length (n+2) |
| cfg_turn | input | 4 | turnaround length (n+1) |
| cfg_width | input | 2 | bus width code |
| cfg_page_en | input | 1 | four-beat page reads |
| cfg_cs_high | input | 1 | chip-select polarity |
| cfg_lane_low | input | 1 | lane-strobe polarity |
| cfg_ext_en | input | 1 | honour the wait input |
| cfg_ext_tmo | input | 10 | hold timeout, 16·(n+1) cycles |
| cfg_wprot | input | 1 | reject writes |
| req_valid | input | 1 | request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | byte address |
| req_be | input | 4 | byte enables |
| req_wdata | input | 32 | write data |
| req_ready | output | 1 | block idle, request taken |
| rsp_valid | output | 1 | read beat data valid |
| rsp_data | output | 32 | read data |
| done | output | 1 | access finished |
| err | output | 1 | access failed (with done) |
| mem_cs | output | 1 | chip select |
| mem_oe_n | output | 1 | output enable, active low |
| mem_we_n | output | 1 | write enable, active low |
| mem_lane | output | 4 | byte lane strobes |
| mem_addr | output | ADDR_W | memory address |
| mem_dout | output | 32 | write data bus |
| mem_dout_en | output | 1 | drive the data bus |
| mem_din | input | 32 | read data bus |
| mem_wait | input | 1 | device wait request, high holds |

## Verification
A wrong phase counter shows up as a chip-select, output-enable or write-enable window that is one or more cycles off. It is visible at the pins during the same access, and `done` moves with it. A wrong beat index or width shift puts a wrong address on the bus. That gives the wrong data word in the very next `rsp_valid`, because the bench memory encodes the address in the data. A hold counter that does not clear, or that compares against a wrong limit, moves the timeout cycle and the `err` flag of the access it occurs in. A turnaround counter fault shows as `req_ready` rising early or late right after `done`.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;
  localparam int LEAD_W  = 4;
  localparam int WAIT_W  = 5;
  localparam int TMO_W   = 10;
  localparam int UNIT_SH = 4;
  localparam int LANES   = 4;
  localparam int BUS_W   = LANES * 8;
  localparam int LEN_W   = WAIT_W + 1;
  localparam int HOLD_W  = TMO_W + UNIT_SH + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_TURN, ST_FAULT} sms_state_e;

  function automatic logic [LEN_W-1:0] beat_len(input logic wr, input logic first,
      input logic [WAIT_W-1:0] rd_w, input logic [WAIT_W-1:0] pg_w,
      input logic [WAIT_W-1:0] wr_w);
    if (wr) return {1'b0, wr_w} + LEN_W'(2);
    if (first) return {1'b0, rd_w} + LEN_W'(1);
    return {1'b0, pg_w} + LEN_W'(1);
  endfunction

  function automatic logic [HOLD_W-1:0] hold_limit(input logic [TMO_W-1:0] n);
    return (HOLD_W'(n) + HOLD_W'(1)) << UNIT_SH;
  endfunction

  function automatic logic [LANES-1:0] width_lanes(input logic [1:0] w);
    case (w)
      2'd0: return LANES'(1);
      2'd1: return LANES'(3);
      2'd2: return {LANES{1'b1}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] m);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction
endpackage

// File: rtl/sms_wait_guard.sv
`timescale 1ns/1ps
module sms_wait_guard
  import sms_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             clear,
  input  logic [TMO_W-1:0] tmo_sel,
  output logic             tmo
);
  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] lim;

  assign lim = hold_limit(tmo_sel);
  assign tmo = hold && (cnt_q == lim - HOLD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!hold || clear) cnt_q <= '0;
    else cnt_q <= cnt_q + HOLD_W'(1);
  end

  assert_hold_within_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim);
  assert_idle_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hold) |-> cnt_q == '0);
endmodule

// File: rtl/sms_pins.sv
`timescale 1ns/1ps
module sms_pins
  import sms_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             oe_act,
  input  logic             we_act,
  input  logic             writing,
  input  logic [LANES-1:0] lanes,
  input  logic             cfg_cs_high,
  input  logic             cfg_lane_low,
  output logic             mem_cs,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_lane
);
  logic strobe;
  logic inv;

  assign strobe   = oe_act | we_act;
  assign inv      = cfg_lane_low | writing;
  assign mem_cs   = cfg_cs_high ? cs_act : !cs_act;
  assign mem_oe_n = !oe_act;
  assign mem_we_n = !we_act;
  assign mem_lane = (strobe ? lanes : '0) ^ {LANES{inv}};

  assert_oe_we_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  assert_strobe_under_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs == cfg_cs_high));
endmodule

// File: rtl/sms_ctrl.sv
`timescale 1ns/1ps
module sms_ctrl
  import sms_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEAD_W-1:0] cfg_we_lead,
  input  logic [LEAD_W-1:0] cfg_oe_lead,
  input  logic [WAIT_W-1:0] cfg_rd_wait,
  input  logic [WAIT_W-1:0] cfg_pg_wait,
  input  logic [WAIT_W-1:0] cfg_wr_wait,
  input  logic [LEAD_W-1:0] cfg_turn,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_page_en,
  input  logic              cfg_ext_en,
  input  logic              cfg_wprot,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              mem_wait,
  input  logic [BUS_W-1:0]  mem_din,
  input  logic              tmo,
  output logic              hold,
  output logic              step_end,
  output logic              cs_act,
  output logic              oe_act,
  output logic              we_act,
  output logic              writing,
  output logic [LANES-1:0]  lanes,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BUS_W-1:0]  mem_dout,
  output logic              mem_dout_en,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_data,
  output logic              done,
  output logic              err
);
  localparam int BEAT_W  = (PAGE_BEATS > 1) ? $clog2(PAGE_BEATS) : 1;
  localparam int SINCE_W = LEAD_W + 1;
  localparam logic [BEAT_W-1:0]  LAST_BEAT = BEAT_W'(PAGE_BEATS - 1);
  localparam logic [SINCE_W-1:0] SINCE_MAX = '1;

  sms_state_e          state_q;
  logic                acc_wr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [BUS_W-1:0]    wdata_q;
  logic [LANES-1:0]    be_q;
  logic [LEN_W-1:0]    k_q;
  logic [BEAT_W-1:0]   beat_q;
  logic [SINCE_W-1:0]  since_q;
  logic [LEAD_W-1:0]   turn_q;
  logic                done_q, err_q, rsp_valid_q;
  logic [BUS_W-1:0]    rsp_data_q;

  logic                in_acc, accept, bad_req, beat_last, more_beats, finish;
  logic [LEN_W-1:0]    len;
  logic [BUS_W-1:0]    din_masked;

  assign in_acc     = (state_q == ST_ACC);
  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign bad_req    = (cfg_width == 2'd3) || (req_write && cfg_wprot);
  assign len        = beat_len(acc_wr_q, beat_q == '0, cfg_rd_wait, cfg_pg_wait, cfg_wr_wait);
  assign beat_last  = in_acc && (k_q == len - LEN_W'(1));
  assign hold       = beat_last && cfg_ext_en && mem_wait;
  assign step_end   = beat_last && (!hold || tmo);
  assign more_beats = !acc_wr_q && cfg_page_en && (beat_q != LAST_BEAT);
  assign finish     = step_end && (tmo || !more_beats);
  assign din_masked = mem_din & lane_bits(width_lanes(cfg_width));

  assign cs_act      = in_acc;
  assign oe_act      = in_acc && !acc_wr_q && (since_q >= {1'b0, cfg_oe_lead});
  assign we_act      = in_acc && acc_wr_q && (since_q > {1'b0, cfg_we_lead});
  assign writing     = in_acc && acc_wr_q;
  assign lanes       = be_q & width_lanes(cfg_width);
  assign mem_addr    = addr_q + (ADDR_W'(beat_q) << cfg_width);
  assign mem_dout    = wdata_q;
  assign mem_dout_en = writing;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;
  assign done        = done_q;
  assign err         = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      acc_wr_q    <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      k_q         <= '0;
      beat_q      <= '0;
      since_q     <= '0;
      turn_q      <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            acc_wr_q <= req_write;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            be_q     <= req_be;
            k_q      <= '0;
            beat_q   <= '0;
            since_q  <= '0;
            if (bad_req) begin
              state_q <= ST_FAULT;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
            end else begin
              state_q <= ST_ACC;
            end
          end
        end
        ST_ACC: begin
          if (since_q != SINCE_MAX) since_q <= since_q + SINCE_W'(1);
          if (step_end) begin
            if (!acc_wr_q && !tmo) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= din_masked;
            end
            if (finish) begin
              state_q <= ST_TURN;
              turn_q  <= '0;
              done_q  <= 1'b1;
              err_q   <= tmo;
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
              k_q    <= '0;
            end
          end else if (!beat_last) begin
            k_q <= k_q + LEN_W'(1);
          end
        end
        ST_TURN: begin
          if (turn_q == cfg_turn) state_q <= ST_IDLE;
          else turn_q <= turn_q + LEAD_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_cs_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bad_req) |=> in_acc);
  assert_done_blocks_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !req_ready);
  assert_rsp_only_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |-> !acc_wr_q);
  assert_oe_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && $past(oe_act)) |-> oe_act);
  assert_we_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && $past(we_act)) |-> we_act);
  assert_hold_freezes_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !tmo) |=> (in_acc && $stable(k_q) && $stable(beat_q)));
  assert_fault_has_error_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_req) |=> (done_q && err_q));
endmodule

// File: rtl/static_mem_sequencer.sv
`timescale 1ns/1ps
module static_mem_sequencer
  import sms_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_we_lead,
  input  logic [3:0]        cfg_oe_lead,
  input  logic [4:0]        cfg_rd_wait,
  input  logic [4:0]        cfg_pg_wait,
  input  logic [4:0]        cfg_wr_wait,
  input  logic [3:0]        cfg_turn,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_page_en,
  input  logic              cfg_cs_high,
  input  logic              cfg_lane_low,
  input  logic              cfg_ext_en,
  input  logic [9:0]        cfg_ext_tmo,
  input  logic              cfg_wprot,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              done,
  output logic              err,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [3:0]        mem_lane,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_dout,
  output logic              mem_dout_en,
  input  logic [31:0]       mem_din,
  input  logic              mem_wait
);
  logic             hold, step_end, tmo;
  logic             cs_act, oe_act, we_act, writing;
  logic [LANES-1:0] lanes;

  sms_ctrl #(.ADDR_W(ADDR_W), .PAGE_BEATS(PAGE_BEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_lead(cfg_we_lead), .cfg_oe_lead(cfg_oe_lead),
    .cfg_rd_wait(cfg_rd_wait), .cfg_pg_wait(cfg_pg_wait),
    .cfg_wr_wait(cfg_wr_wait), .cfg_turn(cfg_turn),
    .cfg_width(cfg_width), .cfg_page_en(cfg_page_en),
    .cfg_ext_en(cfg_ext_en), .cfg_wprot(cfg_wprot),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .mem_wait(mem_wait), .mem_din(mem_din), .tmo(tmo),
    .hold(hold), .step_end(step_end),
    .cs_act(cs_act), .oe_act(oe_act), .we_act(we_act), .writing(writing),
    .lanes(lanes), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .err(err)
  );

  sms_wait_guard u_guard (
    .clk(clk), .rst_n(rst_n), .hold(hold), .clear(step_end),
    .tmo_sel(cfg_ext_tmo), .tmo(tmo)
  );

  sms_pins u_pins (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .oe_act(oe_act),
    .we_act(we_act), .writing(writing), .lanes(lanes),
    .cfg_cs_high(cfg_cs_high), .cfg_lane_low(cfg_lane_low),
    .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lane(mem_lane)
  );

  assert_ready_no_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs != cfg_cs_high));
endmodule

// File: tb/static_mem_sequencer_bench.sv
`timescale 1ns/1ps
module static_mem_sequencer_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [3:0] cfg_we_lead, cfg_oe_lead, cfg_turn;
  logic [4:0] cfg_rd_wait, cfg_pg_wait, cfg_wr_wait;
  logic [1:0] cfg_width;
  logic cfg_page_en, cfg_cs_high, cfg_lane_low, cfg_ext_en, cfg_wprot;
  logic [9:0] cfg_ext_tmo;
  logic req_valid, req_write;
  logic [23:0] req_addr;
  logic [3:0] req_be;
  logic [31:0] req_wdata;
  logic req_ready, rsp_valid, done, err;
  logic [31:0] rsp_data;
  logic mem_cs, mem_oe_n, mem_we_n, mem_dout_en, mem_wait;
  logic [3:0] mem_lane;
  logic [23:0] mem_addr;
  logic [31:0] mem_dout, mem_din;

  static_mem_sequencer u_static_mem_sequencer (.*);

  function automatic logic [31:0] mem_word(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'd3, ~a[7:0], a[7:0] + a[15:8]};
  endfunction
  assign mem_din = mem_word(mem_addr);

  function automatic logic [3:0] wmask(input int w);
    return 4'((1 << (1 << w)) - 1);
  endfunction
  function automatic logic [31:0] dmask(input int w);
    return (w == 2) ? 32'hFFFF_FFFF : 32'((64'd1 << (8 << w)) - 1);
  endfunction

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  int cs_cnt, oe_first, oe_cnt, we_first, we_cnt, done_j, turn_cnt, nrsp;
  logic err_s, dout_en_s;
  logic [31:0] rsp_s [4];
  logic [31:0] dout_s;
  logic [3:0] lane_s;

  task automatic run(input bit wr, input logic [23:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input int wait_x);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cs_cnt = 0; oe_first = -1; oe_cnt = 0; we_first = -1; we_cnt = 0;
    done_j = -1; nrsp = 0; err_s = 0; lane_s = 'x; dout_s = 'x; dout_en_s = 0;
    for (int j = 0; j < 30000; j++) begin
      if (j > 0) @(negedge clk);
      mem_wait = (j < wait_x);
      if (mem_cs === cfg_cs_high) begin
        if (cs_cnt == 0) begin dout_s = mem_dout; dout_en_s = mem_dout_en; end
        cs_cnt++;
      end
      if (mem_oe_n === 1'b0) begin
        if (oe_first < 0) begin oe_first = j; lane_s = mem_lane; end
        oe_cnt++;
      end
      if (mem_we_n === 1'b0) begin
        if (we_first < 0) begin we_first = j; lane_s = mem_lane; end
        we_cnt++;
      end
      if (rsp_valid === 1'b1) begin
        if (nrsp < 4) rsp_s[nrsp] = rsp_data;
        nrsp++;
      end
      if (done === 1'b1) begin done_j = j; err_s = err; break; end
    end
    mem_wait = 1'b0;
    turn_cnt = 0;
    while (req_ready !== 1'b1 && turn_cnt < 100) begin
      turn_cnt++;
      @(negedge clk);
    end
  endtask

  task automatic defaults();
    cfg_we_lead = 0; cfg_oe_lead = 0; cfg_turn = 0; cfg_rd_wait = 2;
    cfg_pg_wait = 1; cfg_wr_wait = 1; cfg_width = 2; cfg_page_en = 0;
    cfg_cs_high = 0; cfg_lane_low = 0; cfg_ext_en = 0; cfg_ext_tmo = 0; cfg_wprot = 0;
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_be = 0;
    req_wdata = 0; mem_wait = 0;
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(req_ready === 1'b1, "R13 ready", req_ready, 1);
    chk(mem_cs === 1'b1, "R13 cs idle", mem_cs, 1);
    chk(mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R13 oe/we", {mem_oe_n, mem_we_n}, 3);
    chk(done === 1'b0, "R13 done", done, 0);

    // R1 R2 R5 R6: non-page read sweep
    for (int rd = 0; rd < 32; rd++) begin
      for (int oe = 0; oe < 16; oe++) begin
        int w; logic [23:0] a; int exp_oe;
        w = (rd + oe) % 3;
        a = 24'(rd * 256 + oe * 8 + 5);
        cfg_rd_wait = 5'(rd); cfg_oe_lead = 4'(oe); cfg_turn = 4'(rd % 5); cfg_width = 2'(w);
        run(0, a, 4'hF, 0, 0);
        exp_oe = (oe <= rd) ? rd + 1 - oe : 0;
        chk(cs_cnt == rd + 1, "R1 read cs length", cs_cnt, rd + 1);
        chk(oe_cnt == exp_oe, "R2 oe length", oe_cnt, exp_oe);
        if (oe <= rd) chk(oe_first == oe, "R2 oe start", oe_first, oe);
        chk(done_j == rd + 1 && !err_s, "R5 done cycle", done_j, rd + 1);
        chk(turn_cnt == (rd % 5) + 1, "R5 turnaround", turn_cnt, (rd % 5) + 1);
        chk(nrsp == 1 && rsp_s[0] == (mem_word(a) & dmask(w)), "R6 read data",
            rsp_s[0], mem_word(a) & dmask(w));
      end
    end
    defaults();

    // R3 write sweep
    for (int wr = 0; wr < 32; wr++) begin
      for (int we = 0; we < 16; we++) begin
        logic [31:0] wd; int exp_we;
        wd = 32'(wr * 32'h01010101 + we * 32'h00110077);
        cfg_wr_wait = 5'(wr); cfg_we_lead = 4'(we);
        run(1, 24'h100, 4'hF, wd, 0);
        exp_we = (we + 1 < wr + 2) ? wr + 1 - we : 0;
        chk(cs_cnt == wr + 2, "R3 write cs length", cs_cnt, wr + 2);
        chk(we_cnt == exp_we, "R3 we length", we_cnt, exp_we);
        if (exp_we > 0) chk(we_first == we + 1, "R3 we start", we_first, we + 1);
        chk(dout_en_s === 1'b1 && dout_s == wd, "R3 write data", dout_s, wd);
        chk(oe_cnt == 0 && done_j == wr + 2, "R3 done/no oe", done_j, wr + 2);
      end
    end
    defaults();

    // R4 page reads
    cfg_page_en = 1;
    for (int rd = 0; rd < 8; rd++) begin
      for (int pg = 0; pg < 32; pg++) begin
        int w, exp_cs; logic [23:0] a;
        w = (rd + pg) % 3;
        a = 24'(rd * 4096 + pg * 16);
        cfg_rd_wait = 5'(rd); cfg_pg_wait = 5'(pg); cfg_width = 2'(w); cfg_oe_lead = 0;
        run(0, a, 4'hF, 0, 0);
        exp_cs = rd + 1 + 3 * (pg + 1);
        chk(cs_cnt == exp_cs && oe_cnt == exp_cs, "R4 page cs/oe length", cs_cnt, exp_cs);
        chk(nrsp == 4, "R4 beat count", nrsp, 4);
        for (int i = 0; i < 4; i++) begin
          logic [31:0] e;
          e = mem_word(a + 24'(i << w)) & dmask(w);
          chk(rsp_s[i] == e, "R4 beat data", rsp_s[i], e);
        end
      end
    end
    defaults();

    // R6 R8 lanes and strobe polarity
    for (int w = 0; w < 3; w++)
      for (int be = 0; be < 16; be++)
        for (int ll = 0; ll < 2; ll++)
          for (int wr = 0; wr < 2; wr++) begin
            logic [3:0] ln, e;
            cfg_width = 2'(w); cfg_lane_low = ll[0];
            run(wr[0], 24'h40, 4'(be), 32'hCAFE0000, 0);
            ln = 4'(be) & wmask(w);
            e = (wr == 0 && ll == 0) ? ln : ~ln;
            chk(lane_s == e, "R8 lane strobe level", lane_s, e);
            chk(mem_lane == (ll ? 4'hF : 4'h0), "R8 lane idle level", mem_lane, ll ? 15 : 0);
          end
    defaults();

    // R7 chip-select polarity
    for (int p = 0; p < 2; p++) begin
      cfg_cs_high = p[0];
      @(negedge clk);
      chk(mem_cs == !p[0], "R7 cs idle level", mem_cs, !p[0]);
      run(0, 24'h10, 4'hF, 0, 0);
      chk(cs_cnt == 3, "R7 cs active count", cs_cnt, 3);
    end
    defaults();

    // R9 wait-pin hold
    cfg_rd_wait = 3; cfg_ext_en = 1; cfg_ext_tmo = 0;
    for (int x = 0; x < 12; x++) begin
      int e;
      run(0, 24'h20, 4'hF, 0, x);
      e = (x <= 3) ? 4 : x + 1;
      chk(cs_cnt == e && !err_s, "R9 held length", cs_cnt, e);
    end
    cfg_ext_en = 0;
    run(0, 24'h20, 4'hF, 0, 1000);
    chk(cs_cnt == 4 && !err_s, "R9 wait ignored when disabled", cs_cnt, 4);

    // R10 timeout
    cfg_ext_en = 1;
    for (int n = 0; n < 4; n++) begin
      int e;
      cfg_ext_tmo = 10'(n * 7);
      run(0, 24'h20, 4'hF, 0, 100000);
      e = 3 + 16 * (n * 7 + 1);
      chk(cs_cnt == e && done_j == e, "R10 timeout length", cs_cnt, e);
      chk(err_s === 1'b1 && nrsp == 0, "R10 timeout error", err_s, 1);
    end
    cfg_ext_tmo = 10'd1023;
    run(1, 24'h20, 4'hF, 1, 100000);
    chk(cs_cnt == 2 + 16384 && err_s === 1'b1, "R10 max timeout write", cs_cnt, 2 + 16384);
    cfg_ext_tmo = 0; cfg_page_en = 1; cfg_rd_wait = 1; cfg_pg_wait = 2;
    run(0, 24'h20, 4'hF, 0, 100000);
    chk(cs_cnt == 17 && err_s === 1'b1 && nrsp == 0, "R10 page timeout", cs_cnt, 17);
    defaults();

    // R11 write protect
    cfg_wprot = 1;
    run(1, 24'h30, 4'hF, 32'h1234, 0);
    chk(done_j == 0 && err_s === 1'b1, "R11 protected write error", done_j, 0);
    chk(cs_cnt == 0 && we_cnt == 0 && turn_cnt == 1, "R11 no strobes", cs_cnt + we_cnt, 0);
    run(0, 24'h30, 4'hF, 0, 0);
    chk(cs_cnt == 3 && err_s === 1'b0 && rsp_s[0] == mem_word(24'h30), "R11 read unaffected",
        cs_cnt, 3);
    defaults();

    // R12 reserved width
    cfg_width = 3;
    for (int wr = 0; wr < 2; wr++) begin
      run(wr[0], 24'h50, 4'hF, 0, 0);
      chk(done_j == 0 && err_s === 1'b1, "R12 reserved width error", done_j, 0);
      chk(cs_cnt == 0 && oe_cnt == 0 && we_cnt == 0, "R12 no strobes", cs_cnt, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule